// File: doc/BRIEF.md
# Tone Burst Gating Controller

This block decides when a 22 kHz signalling tone is sent to a transmit stage and produces the tone as a square wave. A binary divider of the system clock produces a tick every half tone period. The tone can be requested in three ways. A continuous-mode control bit keeps it running. A data-level input gates it, with short start and stop delays. An external timing input gates it while 22 kHz edges arrive on it, and an activity detector decides when that input is live.

The tone leaves the block only while the section is enabled and the transmit-path request is high. The transmit-path enable output is the request gated by the section enable, so standby always closes the path. The internal tone-active flag changes only at the boundary where a high half-cycle starts. Every burst therefore begins and ends with a whole pulse.

Top module: `tone_burst_gate`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `tone_wave`, `tone_active` and `tx_path_en` are all 0.
- R2: `tx_path_en` equals `tx_path_req AND sect_en`, so standby (`sect_en`=0) always forces it to 0.
- R3: `tone_wave` is 1 only while both `sect_en` and `tx_path_req` are 1. Dropping either one cuts the wave at once, even in the middle of a pulse.
- R4: With `tone_cont`=1, `sect_en`=1 and `tx_path_req`=1, `tone_active` settles at 1 and the wave runs without gaps. Its period is 2*HALF_DIV clocks.
- R5: A rising `data_level` starts the tone after one half tone period, counted from the next half tick, plus alignment. The tone is not active within 2 clocks of the rise and is active within 6*HALF_DIV clocks.
- R6: A falling `data_level` stops the tone after two half tone periods plus alignment. The tone is still active 3 clocks after the fall and inactive within 8*HALF_DIV clocks.
- R7: Edges on `ext_timing` make the input active on the first edge. The tone starts after three further half ticks plus alignment, so it is inactive within 2 clocks of the first edge and active within 8*HALF_DIV clocks.
- R8: The external input becomes idle when no edge arrives during three consecutive half ticks. The tone then stops after one more half tick plus alignment. It is still active 4 clocks after the last edge and inactive within 10*HALF_DIV clocks.
- R9: While `sect_en` and `tx_path_req` stay high, every high pulse of `tone_wave` lasts exactly HALF_DIV clocks. No partial pulses are produced.
- R10: `tone_active` changes only in the cycle after a half tick that ends a low half-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sect_en | input | 1 | Section enable; 0 is standby |
| tx_path_req | input | 1 | Transmit-path enable request |
| tone_cont | input | 1 | Continuous tone request bit |
| data_level | input | 1 | Data-level tone gate (asynchronous) |
| ext_timing | input | 1 | External 22 kHz timing square wave (asynchronous) |
| tone_wave | output | 1 | Gated tone square wave |
| tone_active | output | 1 | Tone burst in progress |
| tx_path_en | output | 1 | Transmit-path enable to the output stage |

## Verification
The bench samples each gating source inside its delay window from both sides. A design that skipped the start delay would show the tone 2 clocks after the trigger, and one that never counted the stop delay would stay active past the upper bound. It watches the width of every pulse. A design that opened or closed the gate mid-cycle would produce a pulse shorter than HALF_DIV. It also asks for the tone with the path request low and in standby, which catches any design that lets the wave or the path enable through without both conditions.

// File: rtl/tbg_pkg.sv
// Package: shared delay constants for the tone burst gating controller.
// All delays are counted in half tone periods (half ticks).
package tbg_pkg;
    localparam int unsigned LVL_ON_HT   = 1;  // data-level start delay
    localparam int unsigned LVL_OFF_HT  = 2;  // data-level stop delay
    localparam int unsigned EXT_WIN_HT  = 3;  // edge-free half ticks before idle
    localparam int unsigned EXT_ON_HT   = 3;  // external start delay after first edge
    localparam int unsigned EXT_OFF_HT  = 1;  // extra half tick after idle
endpackage

// File: rtl/tbg_halftick.sv
// Half-period divider: produces a one-clock tick every HALF_DIV clocks and
// a phase flag that toggles on each tick (1 = high half of the tone).
// Assumes HALF_DIV >= 2.
module tbg_halftick #(
    parameter int unsigned HALF_DIV = 2841
) (
    input  logic clk,
    input  logic rst_n,
    output logic half_tick,
    output logic phase_hi
);
    localparam int unsigned CW   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign half_tick = (cnt == LAST);

    // Count clocks within a half period and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            phase_hi <= 1'b0;
        end else if (half_tick) begin
            cnt      <= '0;
            phase_hi <= ~phase_hi;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

    // Ticks are never back to back (R4 period).
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick);
endmodule

// File: rtl/tbg_sync.sv
// Two-flop synchronizer for asynchronous level inputs.
// Assumes the inputs are slow compared with the clock.
module tbg_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta;

    // Two register stages bring the inputs into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            q_sync <= '0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/tbg_ext_activity.sv
// Activity detector for the external timing input: any edge marks it active.
// WIN_HT half ticks without an edge mark it idle.
// Assumes a synchronized input and edge spacing shorter than the window.
module tbg_ext_activity #(
    parameter int unsigned WIN_HT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic ext_s,
    output logic ext_live
);
    localparam int unsigned CW = $clog2(WIN_HT + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_HT - 1);

    logic          ext_d;
    logic          edge_seen;
    logic [CW-1:0] idle_cnt;

    assign edge_seen = ext_s ^ ext_d;

    // Track edges and count half ticks that pass without one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_d    <= 1'b0;
            idle_cnt <= '0;
            ext_live <= 1'b0;
        end else begin
            ext_d <= ext_s;
            if (edge_seen) begin
                idle_cnt <= '0;
                ext_live <= 1'b1;
            end else if (half_tick && ext_live) begin
                if (idle_cnt == WIN_LAST) begin
                    idle_cnt <= '0;
                    ext_live <= 1'b0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end

    // Going active needs an edge, and going idle happens only on a tick (R7, R8).
    p_live_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_live) |-> $past(edge_seen));
    p_live_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_live) |-> $past(half_tick));
endmodule

// File: rtl/tbg_delay_gate.sv
// Delay gate: its output follows a request only after the request has held
// its new value for ON_HT (rising) or OFF_HT (falling) half ticks.
// A request that reverts during the count restarts it.
module tbg_delay_gate #(
    parameter int unsigned ON_HT  = 1,
    parameter int unsigned OFF_HT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic req,
    output logic gated
);
    localparam int unsigned MAXHT = (ON_HT > OFF_HT) ? ON_HT : OFF_HT;
    localparam int unsigned CW    = $clog2(MAXHT + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_HT - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_HT - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = gated ? OFF_LAST : ON_LAST;

    // Count half ticks while the request disagrees with the output, then follow it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gated <= 1'b0;
            cnt   <= '0;
        end else if (req == gated) begin
            cnt   <= '0;
        end else if (half_tick) begin
            if (cnt == lim) begin
                gated <= req;
                cnt   <= '0;
            end else begin
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // The output moves only on a tick (R5, R6).
    p_gate_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gated != $past(gated)) |-> $past(half_tick));
    p_gate_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gated != $past(gated)) |-> (gated == $past(req)));
endmodule

// File: rtl/tone_burst_gate.sv
// Tone burst gating controller. It merges the continuous bit, the data-level
// gate and the external timing activity into one tone request. The active
// flag is aligned to whole tone cycles, and the wave is gated by section and
// transmit-path enables. Assumes HALF_DIV >= 2 and slow asynchronous inputs.
module tone_burst_gate
    import tbg_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2841
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sect_en,
    input  logic tx_path_req,
    input  logic tone_cont,
    input  logic data_level,
    input  logic ext_timing,
    output logic tone_wave,
    output logic tone_active,
    output logic tx_path_en
);
    localparam int unsigned NSYNC = 2;

    logic             half_tick;
    logic             phase_hi;
    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_in;
    logic             lvl_gate;
    logic             ext_live;
    logic             ext_gate;
    logic             want;

    tbg_halftick #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .phase_hi(phase_hi)
    );

    assign raw_in = {ext_timing, data_level};

    tbg_sync #(.WIDTH(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(sync_in)
    );

    tbg_delay_gate #(.ON_HT(LVL_ON_HT), .OFF_HT(LVL_OFF_HT)) u_lvl_gate (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .req(sync_in[0]), .gated(lvl_gate)
    );

    tbg_ext_activity #(.WIN_HT(EXT_WIN_HT)) u_ext_act (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .ext_s(sync_in[1]), .ext_live(ext_live)
    );

    tbg_delay_gate #(.ON_HT(EXT_ON_HT), .OFF_HT(EXT_OFF_HT)) u_ext_gate (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .req(ext_live), .gated(ext_gate)
    );

    assign tx_path_en = sect_en & tx_path_req;
    assign want       = tx_path_en & (tone_cont | lvl_gate | ext_gate);

    // Update the active flag only where a low half ends, so bursts hold whole pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_active <= 1'b0;
        end else if (half_tick && !phase_hi) begin
            tone_active <= want;
        end
    end

    assign tone_wave = tone_active & phase_hi & tx_path_en;

    // Wave only with both enables present.
    p_wave_needs_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tone_wave |-> (sect_en && tx_path_req));
    // Standby closes the transmit path.
    p_standby_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sect_en |-> !tx_path_en);
    // The active flag moves only on a low-to-high half boundary.
    p_active_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_active != $past(tone_active)) |-> ($past(half_tick) && phase_hi));
    // A fresh burst opens at the start of a high half (R9).
    p_burst_starts_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tone_active) && tx_path_en) |-> tone_wave);
endmodule

// File: tb/tone_burst_gate_bench.sv
module tone_burst_gate_bench;
    localparam int unsigned HD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sect_en = 1'b0, tx_path_req = 1'b0, tone_cont = 1'b0;
    logic data_level = 1'b0, ext_timing = 1'b0;
    logic tone_wave, tone_active, tx_path_en;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    tone_burst_gate #(.HALF_DIV(HD)) u_tone_burst_gate (
        .clk(clk), .rst_n(rst_n), .sect_en(sect_en), .tx_path_req(tx_path_req),
        .tone_cont(tone_cont), .data_level(data_level), .ext_timing(ext_timing),
        .tone_wave(tone_wave), .tone_active(tone_active), .tx_path_en(tx_path_en)
    );

    // Vector: {sect_en, tx_path_req, tone_cont, expected tone_active}
    localparam logic [3:0] VEC [7] = '{4'b1111, 4'b1100, 4'b1010, 4'b0110,
                                       4'b1111, 4'b0010, 4'b1000};

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse-width monitor (R9): every high run must be HD clocks while the path stays open.
    int run_len = 0;
    int width_err = 0;
    int rises = 0;
    logic mon_on = 1'b0;
    always @(negedge clk) begin
        if (tone_wave) begin
            if (run_len == 0) rises++;
            run_len++;
        end else begin
            if (run_len != 0 && mon_on && run_len != HD) width_err++;
            run_len = 0;
        end
    end

    initial begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        clks(3);
        check(tone_wave, 1'b0, "R1 wave in reset");
        check(tone_active, 1'b0, "R1 active in reset");
        check(tx_path_en, 1'b0, "R1 path in reset");
        rst_n = 1'b1;
        clks(1);
        check(tone_active, 1'b0, "R1 active after release");

        // Table walk: continuous bit and enables (R2, R4, R3)
        foreach (VEC[i]) begin
            sect_en = VEC[i][3]; tx_path_req = VEC[i][2]; tone_cont = VEC[i][1];
            clks(30);
            check(tone_active, VEC[i][0], "R4 table active");
            check(tx_path_en, VEC[i][3] & VEC[i][2], "R2 table path");
            if (!(VEC[i][3] & VEC[i][2])) begin
                int seen = 0;
                for (int k = 0; k < 40; k++) begin
                    clks(1);
                    if (tone_wave) seen++;
                end
                check(seen != 0, 1'b0, "R3 wave blocked");
            end
        end

        // R4 period and R9 width in continuous mode
        sect_en = 1; tx_path_req = 1; tone_cont = 1;
        clks(30);
        mon_on = 1'b1;
        rises = 0;
        clks(80);
        check(rises >= 9 && rises <= 11, 1'b1, "R4 pulse count in 80 clocks");
        tone_cont = 0;
        clks(30);
        check(tone_active, 1'b0, "R4 continuous released");

        // R5/R6 data-level gating
        data_level = 1;
        clks(2);
        check(tone_active, 1'b0, "R5 no early start");
        clks(6*HD - 2);
        check(tone_active, 1'b1, "R5 started");
        clks(20);
        data_level = 0;
        clks(3);
        check(tone_active, 1'b1, "R6 no early stop");
        clks(8*HD - 3);
        check(tone_active, 1'b0, "R6 stopped");

        // R7/R8 external timing input
        clks(20);
        ext_timing = ~ext_timing;
        clks(2);
        check(tone_active, 1'b0, "R7 no early start");
        for (int k = 0; k < 15; k++) begin
            clks(HD);
            ext_timing = ~ext_timing;
        end
        check(tone_active, 1'b1, "R7 started");
        clks(4);
        check(tone_active, 1'b1, "R8 no early stop");
        clks(10*HD - 4);
        check(tone_active, 1'b0, "R8 stopped");

        // R3 cut mid-burst and R2 standby
        tone_cont = 1;
        clks(30);
        mon_on = 1'b0;
        @(posedge tone_wave);
        clks(1);
        sect_en = 0;
        #1;
        check(tone_wave, 1'b0, "R3 cut in standby");
        check(tx_path_en, 1'b0, "R2 standby path");
        clks(30);
        check(tone_active, 1'b0, "R3 inactive in standby");

        check(width_err == 0, 1'b1, "R9 full pulses");
        // R10 is guarded by p_active_aligned_r10 in the design
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule